// File: doc/BRIEF.md
# Panel Refresh Scan and Tearing-Effect Timing Generator

This block is the refresh engine on the panel side of a display controller that has its own frame memory. It divides the reference clock into line periods, counts the lines of each refresh, and outputs the index of the memory line being scanned. It also drives a tearing-effect output. The host waits for a pulse on this output before it writes a new image, so that its writes stay behind the panel's reads and no torn frame is shown.

A line lasts `clks_per_line × divider` reference clocks. With the default 448 lines per frame (432 visible plus two 8-line porches), the refresh rate is the reference frequency divided by `clks_per_line × divider × 448`. The tearing output can be restricted to every Nth refresh and can be moved down the frame by a programmed number of lines. This gives the host a write start that falls after the old contents have been read. In the combined mode, a short pulse also marks the start of every line, and the frame pulse differs from the line pulses by its width. The timing configuration is taken only at the start of each frame, so a frame is never scanned with mixed settings. The enable input acts at once.

Top module: `panel_scan_te`

## Requirements
- R1: During reset `frame_start`, `line_start`, `read_line` and `te` are all 0. The first clock edge after reset is released starts frame 0, so `frame_start` is 1 for the following cycle.
- R2: `line_start` pulses for one cycle once every `max(cfg_clks_per_line,1) × max(cfg_div,1)` clocks. A value of 0 in either field counts as 1.
- R3: `read_line` increments by one at each `line_start` and holds its value between them. It wraps from LINES-1 (447 by default) to 0. `frame_start` pulses together with `line_start` in exactly the cycle that line 0 begins.
- R4: Frames are numbered from 0 after reset. Frame k carries a frame pulse only when k mod `max(cfg_te_every,1)` is 0.
- R5: In a frame that carries a frame pulse, `te` is high for the whole of line `min(cfg_te_delay, LINES-1)`, which is exactly one line period.
- R6: When `cfg_te_mode` is 1, `te` is also high for the first LP_CLKS clocks of every line. When `cfg_te_mode` is 0, no line pulses occur. A frame pulse is therefore longer than a line pulse whenever the line period exceeds LP_CLKS.
- R7: The clocks-per-line count, the divider, the interval, the delay and the mode are sampled only in the cycle a frame begins. A change made during a frame first takes effect in the next frame.
- R8: `cfg_te_en` is not latched. When it is 0 at a clock edge, `te` is 0 in the cycle after that edge.
- R9: The outputs are registered and all carry the same latency, so `te`, `read_line`, `line_start` and `frame_start` describe the same scan position in any given cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_clks_per_line | input | CPL_W | Divided clocks per line; 0 acts as 1 |
| cfg_div | input | DIV_W | Reference clock divider; 0 acts as 1 |
| cfg_te_every | input | EV_W | Refreshes per frame pulse; 0 acts as 1 |
| cfg_te_delay | input | LINE_W | Line on which the frame pulse is placed |
| cfg_te_mode | input | 1 | 0: frame pulses only; 1: frame and line pulses |
| cfg_te_en | input | 1 | Gates `te`; acts immediately |
| read_line | output | LINE_W | Frame memory line being scanned |
| line_start | output | 1 | One-cycle pulse at each line start |
| frame_start | output | 1 | One-cycle pulse at each frame start |
| te | output | 1 | Tearing-effect (frame mark) output |

## Verification
If the divider or line counter slips, the spacing of `line_start` is off by at least one clock within the first line. A wrong line count moves the `frame_start`/`read_line` wrap within one frame. A wrong frame-interval count is visible only at the next marked frame, up to N frames later. A wrong delay comparison moves the wide `te` pulse to a different line in the first frame after reset. A config latch that is transparent mid-frame shows up as a line period that changes within a frame, in the same line that the change was made.

// File: rtl/panel_te_pkg.sv
package panel_te_pkg;

   typedef enum logic {
      TE_FRAME_ONLY     = 1'b0,
      TE_FRAME_AND_LINE = 1'b1
   } te_mode_e;

endpackage

// File: rtl/panel_scan_timer.sv
module panel_scan_timer #(
   parameter int LINES = 448,
   parameter int CPL_W = 8,
   parameter int DIV_W = 4,
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_eff,
   input  logic [CPL_W-1:0]  cpl_eff,
   output logic [LINE_W-1:0] line_idx,
   output logic              line_begin,
   output logic              at_origin
);
   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

   logic [DIV_W-1:0]  pre_q;
   logic [CPL_W-1:0]  dot_q;
   logic [LINE_W-1:0] line_q;
   logic              pre_last, dot_last, line_last;

   assign pre_last   = (pre_q == div_eff - 1'b1);
   assign dot_last   = (dot_q == cpl_eff - 1'b1);
   assign line_last  = (line_q == LAST_LINE);
   assign line_begin = (pre_q == '0) && (dot_q == '0);
   assign at_origin  = line_begin && (line_q == '0);
   assign line_idx   = line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q  <= '0;
         dot_q  <= '0;
         line_q <= '0;
      end else if (!pre_last) begin
         pre_q <= pre_q + 1'b1;
      end else begin
         pre_q <= '0;
         if (!dot_last) begin
            dot_q <= dot_q + 1'b1;
         end else begin
            dot_q  <= '0;
            line_q <= line_last ? '0 : line_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/panel_te_gen.sv
module panel_te_gen import panel_te_pkg::*; #(
   parameter int LINES       = 448,
   parameter int EV_W        = 4,
   parameter int LP_CLKS     = 4,
   parameter bit LINE_PULSES = 1'b1,
   localparam int LINE_W = $clog2(LINES),
   localparam int OFF_W  = $clog2(LP_CLKS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              at_origin,
   input  logic              line_begin,
   input  logic [LINE_W-1:0] line_idx,
   input  logic [EV_W-1:0]   every_eff,
   input  logic [LINE_W-1:0] delay_eff,
   input  te_mode_e          mode,
   input  logic              te_en,
   output logic              te
);
   logic [EV_W-1:0] fcnt_q;
   logic [EV_W:0]   fcnt_inc;
   logic            mark_q, mark_cur;
   logic            frame_hit, line_hit;

   assign fcnt_inc  = {1'b0, fcnt_q} + 1'b1;
   assign mark_cur  = at_origin ? (fcnt_q == '0) : mark_q;
   assign frame_hit = mark_cur && (line_idx == delay_eff);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fcnt_q <= '0;
         mark_q <= 1'b0;
      end else begin
         mark_q <= mark_cur;
         if (at_origin)
            fcnt_q <= (fcnt_inc >= {1'b0, every_eff}) ? '0 : fcnt_inc[EV_W-1:0];
      end
   end

   generate
      if (LINE_PULSES) begin : g_line_pulse
         logic [OFF_W-1:0] off_q, off_cur;
         assign off_cur  = line_begin ? '0 : off_q;
         assign line_hit = (mode == TE_FRAME_AND_LINE) && (off_cur < OFF_W'(LP_CLKS));
         always_ff @(posedge clk) begin
            if (!rst_n)
               off_q <= '0;
            else
               off_q <= (off_cur == OFF_W'(LP_CLKS)) ? off_cur : off_cur + 1'b1;
         end
      end else begin : g_no_line_pulse
         assign line_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         te <= 1'b0;
      else
         te <= te_en && (frame_hit || line_hit);
   end
endmodule

// File: rtl/panel_scan_te.sv
module panel_scan_te import panel_te_pkg::*; #(
   parameter int LINES       = 448,
   parameter int CPL_W       = 8,
   parameter int DIV_W       = 4,
   parameter int EV_W        = 4,
   parameter int LP_CLKS     = 4,
   parameter bit LINE_PULSES = 1'b1,
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPL_W-1:0]  cfg_clks_per_line,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [EV_W-1:0]   cfg_te_every,
   input  logic [LINE_W-1:0] cfg_te_delay,
   input  logic              cfg_te_mode,
   input  logic              cfg_te_en,
   output logic [LINE_W-1:0] read_line,
   output logic              line_start,
   output logic              frame_start,
   output logic              te
);
   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

   generate
      if (LINES < 2)   begin : g_bad_lines   $error("LINES must be at least 2");   end
      if (LP_CLKS < 1) begin : g_bad_lp      $error("LP_CLKS must be at least 1"); end
      if (EV_W < 1)    begin : g_bad_ev      $error("EV_W must be at least 1");    end
   endgenerate

   logic              at_origin, line_begin;
   logic [LINE_W-1:0] line_idx;

   logic [CPL_W-1:0]  cpl_hold, cpl_cur, cpl_eff;
   logic [DIV_W-1:0]  div_hold, div_cur, div_eff;
   logic [EV_W-1:0]   ev_hold, ev_cur, ev_eff;
   logic [LINE_W-1:0] dly_hold, dly_cur, dly_eff;
   te_mode_e          mode_hold, mode_cur;

   always_comb begin
      cpl_cur  = at_origin ? cfg_clks_per_line         : cpl_hold;
      div_cur  = at_origin ? cfg_div                   : div_hold;
      ev_cur   = at_origin ? cfg_te_every              : ev_hold;
      dly_cur  = at_origin ? cfg_te_delay              : dly_hold;
      mode_cur = at_origin ? te_mode_e'(cfg_te_mode)   : mode_hold;
      cpl_eff  = (cpl_cur == '0) ? CPL_W'(1) : cpl_cur;
      div_eff  = (div_cur == '0) ? DIV_W'(1) : div_cur;
      ev_eff   = (ev_cur  == '0) ? EV_W'(1)  : ev_cur;
      dly_eff  = (dly_cur > LAST_LINE) ? LAST_LINE : dly_cur;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpl_hold  <= '0;
         div_hold  <= '0;
         ev_hold   <= '0;
         dly_hold  <= '0;
         mode_hold <= TE_FRAME_ONLY;
      end else begin
         cpl_hold  <= cpl_cur;
         div_hold  <= div_cur;
         ev_hold   <= ev_cur;
         dly_hold  <= dly_cur;
         mode_hold <= mode_cur;
      end
   end

   panel_scan_timer #(.LINES(LINES), .CPL_W(CPL_W), .DIV_W(DIV_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .div_eff    (div_eff),
      .cpl_eff    (cpl_eff),
      .line_idx   (line_idx),
      .line_begin (line_begin),
      .at_origin  (at_origin)
   );

   panel_te_gen #(.LINES(LINES), .EV_W(EV_W), .LP_CLKS(LP_CLKS),
                  .LINE_PULSES(LINE_PULSES)) u_te (
      .clk        (clk),
      .rst_n      (rst_n),
      .at_origin  (at_origin),
      .line_begin (line_begin),
      .line_idx   (line_idx),
      .every_eff  (ev_eff),
      .delay_eff  (dly_eff),
      .mode       (mode_cur),
      .te_en      (cfg_te_en),
      .te         (te)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         read_line   <= '0;
         line_start  <= 1'b0;
         frame_start <= 1'b0;
      end else begin
         read_line   <= line_idx;
         line_start  <= line_begin;
         frame_start <= at_origin;
      end
   end
endmodule

// File: rtl/panel_scan_te_chk.sv
module panel_scan_te_chk #(
   parameter int LINES = 448,
   localparam int LINE_W = $clog2(LINES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_te_en,
   input logic [LINE_W-1:0] read_line,
   input logic              line_start,
   input logic              frame_start,
   input logic              te
);
   logic seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n)          seen_q <= 1'b0;
      else if (frame_start) seen_q <= 1'b1;
   end

   p_frame_line0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (read_line == '0) && line_start);

   p_line_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      read_line <= LINE_W'(LINES - 1));

   p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !frame_start) |-> (read_line == $past(read_line) + 1'b1));

   p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |-> $stable(read_line));

   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && seen_q) |-> ($past(read_line) == LINE_W'(LINES - 1)));

   p_te_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_te_en |=> !te);
endmodule

bind panel_scan_te panel_scan_te_chk #(.LINES(LINES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_te_en   (cfg_te_en),
   .read_line   (read_line),
   .line_start  (line_start),
   .frame_start (frame_start),
   .te          (te)
);

// File: tb/panel_scan_te_test.sv
module panel_scan_te_test;
   localparam int LINES = 6;
   localparam int CPL_W = 4;
   localparam int DIV_W = 3;
   localparam int EV_W  = 3;
   localparam int LPC   = 2;
   localparam int LW    = $clog2(LINES);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [CPL_W-1:0] cfg_cpl = '0;
   logic [DIV_W-1:0] cfg_div = '0;
   logic [EV_W-1:0]  cfg_ev = '0;
   logic [LW-1:0]    cfg_dly = '0;
   logic             cfg_mode = 1'b0;
   logic             cfg_en = 1'b1;
   logic [LW-1:0]    read_line;
   logic             line_start, frame_start, te;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   panel_scan_te #(.LINES(LINES), .CPL_W(CPL_W), .DIV_W(DIV_W), .EV_W(EV_W),
                   .LP_CLKS(LPC), .LINE_PULSES(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_clks_per_line(cfg_cpl), .cfg_div(cfg_div), .cfg_te_every(cfg_ev),
      .cfg_te_delay(cfg_dly), .cfg_te_mode(cfg_mode), .cfg_te_en(cfg_en),
      .read_line(read_line), .line_start(line_start),
      .frame_start(frame_start), .te(te));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   // pending config, as the bench drives it
   int p_cpl, p_div, p_ev, p_dly, p_mode;

   task automatic drive_cfg();
      cfg_cpl  = CPL_W'(p_cpl);
      cfg_div  = DIV_W'(p_div);
      cfg_ev   = EV_W'(p_ev);
      cfg_dly  = LW'(p_dly);
      cfg_mode = p_mode[0];
   endtask

   // reset, then check frames cycle by cycle; optional mid-frame config change
   // (R7) and optional enable drop (R8)
   task automatic run(input int nf, input bit do_chg, input bit do_en);
      int ev_e;
      cfg_en = 1'b1;
      drive_cfg();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 frame_start in reset", frame_start, 0);
      chk("R1 line_start in reset", line_start, 0);
      chk("R1 read_line in reset", read_line, 0);
      chk("R1 te in reset", te, 0);
      rst_n = 1'b1;
      @(negedge clk);
      ev_e = (p_ev == 0) ? 1 : p_ev;
      for (int f = 0; f < nf; f++) begin
         int cpl_e, div_e, dly_e, md, per, fp;
         bit mark;
         cpl_e = (p_cpl == 0) ? 1 : p_cpl;
         div_e = (p_div == 0) ? 1 : p_div;
         dly_e = (p_dly > LINES - 1) ? LINES - 1 : p_dly;
         md    = p_mode;
         per   = cpl_e * div_e;
         fp    = per * LINES;
         mark  = (f % ev_e) == 0;
         for (int t = 0; t < fp; t++) begin
            int ln, off, exp_te;
            ln  = t / per;
            off = t % per;
            exp_te = (cfg_en && ((mark && ln == dly_e) || (md == 1 && off < LPC))) ? 1 : 0;
            chk("R1 R3 frame_start", frame_start, (t == 0) ? 1 : 0);
            chk("R2 line_start", line_start, (off == 0) ? 1 : 0);
            chk("R3 read_line", read_line, ln);
            chk((off < LPC) ? "R6 R9 te" : "R4 R5 te", te, exp_te);
            if (do_chg && f == 0 && t == 2) begin
               p_cpl = (p_cpl % 4) + 2;
               p_div = (p_div % 2) + 1;
               p_dly = (p_dly + 1) % LINES;
               p_mode = 1 - p_mode;
               drive_cfg();
            end
            if (do_en)
               cfg_en = !(f == 1 && t >= 1 && t < 2 * per + 1);
            @(negedge clk);
         end
      end
      chk("R3 frame_start after last frame", frame_start, 1);
   endtask

   initial begin
      int dl[4];
      dl = '{0, 2, 5, 7};
      for (int i = 0; i < 40; i++) begin
         p_cpl  = i % 5;
         p_div  = i % 3;
         p_ev   = i % 4;
         p_dly  = dl[(i / 5) % 4];
         p_mode = (i / 2) % 2;
         run(4, 1'b0, 1'b0);
      end
      // R7: mid-frame change applies from the next frame
      p_cpl = 3; p_div = 2; p_ev = 1; p_dly = 1; p_mode = 0;
      run(3, 1'b1, 1'b0);
      p_cpl = 0; p_div = 3; p_ev = 2; p_dly = 4; p_mode = 1;
      run(3, 1'b1, 1'b0);
      // R8: enable drop gates te immediately
      p_cpl = 4; p_div = 1; p_ev = 1; p_dly = 1; p_mode = 1;
      run(3, 1'b0, 1'b1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule